// File: doc/BRIEF.md
# Manchester Line Decoder with Recovered Bit Clock

This block takes a Manchester-coded serial line, samples it with a free-running oversampling clock, and rebuilds both the bit stream and a bit clock from it. The line passes through a synchronizer. A counter then measures the gap between successive line transitions in oversampling cycles. Each gap is sorted as short, half-bit, full-bit or long, and a small tracker uses that sequence to tell mid-bit transitions apart from bit-boundary transitions. Each accepted mid-bit transition yields one decoded bit.

The decoded bit is presented inverted on `data_n`. A bit-rate clock, `rec_clk`, rises once per decoded bit, after `data_n` has settled. When the following bit repeats the value, the clock's high phase is ended by the line's own boundary transition, so it copies the received pulse. When the following bit is the complement, there is no boundary transition, and the clock is pulled low after a nominal half bit. The clock's duty cycle therefore follows the received pulse widths. Gaps that break the coding rules raise a sticky violation flag, drop lock and suppress the bit concerned.

The oversampling ratio `OSR` is fixed by parameter and must be a multiple of 4 and at least 8. Below, Q = OSR/4 and HALF = OSR/2 oversampling cycles. All gaps are counted in oversampling cycles.

Top module: `manch_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rec_clk` is 0, `data_n` is 1, `locked` is 0 and `viol` is 0.
- R2: A bit of value 1 is coded as low for the first half and high for the second half (rising mid-bit transition). A bit of value 0 is coded as high then low (falling mid-bit transition). `data_n` carries the inverse of each decoded bit.
- R3: `rec_clk` shows exactly one rising edge per decoded bit, in the order the bits were sent. `data_n` is updated at least one oversampling cycle before that edge and is stable at it.
- R4: From reset, and after any loss of lock, transitions are ignored until two transitions arrive a full-bit gap apart (3Q to 5Q cycles inclusive). The second of them is taken as a mid-bit transition, decoded, and sets `locked`. No `rec_clk` rising edge occurs while unlocked.
- R5: If a decoded bit is followed by the same value, `rec_clk` falls in the same cycle as the synchronized boundary transition. With no jitter its high time is HALF−1 cycles.
- R6: If a decoded bit is followed by its complement, or by no further transition, `rec_clk` stays high for exactly HALF cycles. It then stays low until the next decoded bit. No high phase ever exceeds HALF cycles.
- R7: While locked, half-bit gaps anywhere in [Q, 3Q) and full-bit gaps anywhere in [3Q, 5Q] decode without error, so bounded pulse-width jitter is tolerated.
- R8: While locked, a gap shorter than Q sets `viol` and clears `locked`. No further bit is decoded until lock is regained.
- R9: While locked, a full-bit gap that directly follows a boundary transition (a pulse stretched past 3Q) sets `viol` and clears `locked`. The bit it would have completed is not decoded and gives no `rec_clk` edge.
- R10: While locked, if no transition arrives for more than 5Q cycles, `locked` clears and `viol` is left unchanged (end of a burst).
- R11: `viol` is sticky: once set it stays set, even across later good traffic and relock, until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR cycles per bit |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Manchester-coded serial line, asynchronous |
| rec_clk | output | 1 | Recovered bit clock, rising once per decoded bit |
| data_n | output | 1 | Inverted decoded bit, valid at `rec_clk` rise |
| locked | output | 1 | Decoder has found mid-bit phase |
| viol | output | 1 | Sticky coding-violation flag |

## Verification
On every cycle, the assertions check the following:
- a high phase of `rec_clk` never exceeds HALF cycles;
- `data_n` is steady at each rising edge of `rec_clk`;
- a line transition during a high phase ends it;
- every rising edge happens while locked;
- a rule violation always drops lock;
- a timeout unlocks without touching the flag;
- the flag never falls.

Only the bench's stimulus can show what the assertions cannot. That covers three things:
- that the right bits come out in the right order under random data and jitter;
- that the high time follows the next bit's value;
- that a stream with no full-bit gap never locks and a glitched or stretched pulse costs exactly the affected bit.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

  // Class of the gap between two line transitions, in oversampling cycles
  typedef enum logic [1:0] {
    GAP_SHORT,
    GAP_HALF,
    GAP_FULL,
    GAP_LONG
  } gap_e;

  // Sort a gap of n cycles given the quarter-bit length
  function automatic gap_e gap_class(input int unsigned n, input int unsigned quarter);
    if (n < quarter) begin
      return GAP_SHORT;
    end else if (n < 3 * quarter) begin
      return GAP_HALF;
    end else if (n <= 5 * quarter) begin
      return GAP_FULL;
    end
    return GAP_LONG;
  endfunction

endpackage

// File: rtl/manch_rx_sync.sv
module manch_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic tog
);

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-1:0], din};
    end
  end

  assign level = sh_q[STAGES-1];
  assign tog   = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/manch_rx_gap.sv
module manch_rx_gap
  import manch_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tog,
  output gap_e gap,
  output logic stale
);

  localparam int unsigned QTR   = OSR / 4;
  localparam int unsigned LIMIT = 5 * QTR;
  localparam int unsigned CW    = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] CAP = CW'(LIMIT + 1);

  // Cycles since the last transition; saturates at CAP (reset value: "long ago")
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CAP;
    end else if (tog) begin
      cnt_q <= CW'(1);
    end else if (cnt_q != CAP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gap   = gap_class(32'(cnt_q), QTR);
  assign stale = (cnt_q == CAP);

endmodule

// File: rtl/manch_rx_track.sv
module manch_rx_track
  import manch_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tog,
  input  logic level,
  input  gap_e gap,
  input  logic stale,
  output logic mid_evt,
  output logic mid_bit,
  output logic locked,
  output logic viol
);

  logic lock_q;
  logic at_mid_q;
  logic viol_q;
  logic bad;
  logic drop;

  // Decide what the current transition means
  always_comb begin
    mid_evt = 1'b0;
    bad     = 1'b0;
    if (tog) begin
      if (!lock_q) begin
        mid_evt = (gap == GAP_FULL);
      end else begin
        unique case (gap)
          GAP_HALF: mid_evt = !at_mid_q;
          GAP_FULL: begin
            mid_evt = at_mid_q;
            bad     = !at_mid_q;
          end
          default:  bad = 1'b1;
        endcase
      end
    end
  end

  assign drop    = lock_q & ~tog & stale;
  assign mid_bit = level;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      at_mid_q <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      if (bad || drop) begin
        lock_q <= 1'b0;
      end else if (mid_evt) begin
        lock_q <= 1'b1;
      end
      if (tog) begin
        at_mid_q <= mid_evt;
      end
      if (bad) begin
        viol_q <= 1'b1;
      end
    end
  end

  assign locked = lock_q;
  assign viol   = viol_q;

  AST_VIOL_HOLDS: assert property (@(posedge clk) disable iff (rst) viol_q |=> viol_q); // R11
  AST_BAD_UNLOCKS: assert property (@(posedge clk) disable iff (rst) bad |=> (!lock_q && viol_q)); // R8
  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    drop |=> (!lock_q && (viol_q == $past(viol_q)))); // R10

endmodule

// File: rtl/manch_rx_clkgen.sv
module manch_rx_clkgen #(
  parameter int unsigned HALF = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mid_evt,
  input  logic mid_bit,
  input  logic tog,
  output logic rec_clk,
  output logic data_n
);

  localparam int unsigned HW = $clog2(HALF + 1);

  logic          pend_q;
  logic          rc_q;
  logic          dn_q;
  logic [HW-1:0] hcnt_q;
  logic [HW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      rc_q   <= 1'b0;
      dn_q   <= 1'b1;
      hcnt_q <= '0;
    end else begin
      pend_q <= mid_evt;
      if (mid_evt) begin
        dn_q <= ~mid_bit;
      end
      if (pend_q) begin
        rc_q   <= 1'b1;
        hcnt_q <= HW'(1);
      end else if (rc_q) begin
        if (tog || (hcnt_q >= HW'(HALF))) begin
          rc_q <= 1'b0;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end
  end

  assign rec_clk = rc_q;
  assign data_n  = dn_q;

  // Independent high-run counter for the checks below
  always_ff @(posedge clk) begin
    if (rst || !rc_q) begin
      run_q <= '0;
    end else if (run_q != HW'(HALF)) begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_HIGH_BOUNDED: assert property (@(posedge clk) disable iff (rst) rc_q |-> (run_q < HW'(HALF))); // R6
  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (rst) $rose(rc_q) |-> $stable(dn_q)); // R3
  AST_FALL_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    (rc_q && tog && !pend_q) |=> !rc_q); // R5

endmodule

// File: rtl/manch_rx.sv
module manch_rx
  import manch_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic rec_clk,
  output logic data_n,
  output logic locked,
  output logic viol
);

  localparam int unsigned HALF = OSR / 2;

  logic tog;
  logic level;
  gap_e gap;
  logic stale;
  logic mid_evt;
  logic mid_bit;

  manch_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (line_in),
    .level (level),
    .tog   (tog)
  );

  manch_rx_gap #(.OSR(OSR)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .tog   (tog),
    .gap   (gap),
    .stale (stale)
  );

  manch_rx_track u_track (
    .clk     (clk),
    .rst     (rst),
    .tog     (tog),
    .level   (level),
    .gap     (gap),
    .stale   (stale),
    .mid_evt (mid_evt),
    .mid_bit (mid_bit),
    .locked  (locked),
    .viol    (viol)
  );

  manch_rx_clkgen #(.HALF(HALF)) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .mid_evt (mid_evt),
    .mid_bit (mid_bit),
    .tog     (tog),
    .rec_clk (rec_clk),
    .data_n  (data_n)
  );

  AST_RISE_LOCKED: assert property (@(posedge clk) disable iff (rst) $rose(rec_clk) |-> locked); // R4

endmodule

// File: tb/manch_rx_test.sv
module manch_rx_test;
  localparam int OSR  = 16;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  logic rc, dn, lk, vf;

  manch_rx #(.OSR(OSR)) uut (
    .clk(clk), .rst(rst), .line_in(line),
    .rec_clk(rc), .data_n(dn), .locked(lk), .viol(vf)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int rx_n  = 0;
  logic rx_d [0:1023];
  int   rx_w [0:1023];
  int   cur_w = 0;
  logic prev_rc = 1'b0;
  logic exp_b [0:1023];
  int   exp_n = 0;

  // Monitor: sample one time unit after each rising clock edge
  always @(posedge clk) begin
    #1;
    if (rc && !prev_rc) begin
      if (rx_n < 1024) rx_d[rx_n] = dn;
      rx_n++;
      cur_w = 1;
    end else if (rc) begin
      cur_w++;
    end else if (prev_rc && rx_n > 0 && rx_n <= 1024) begin
      rx_w[rx_n-1] = cur_w;
    end
    prev_rc = rc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int jit(input int span);
    return int'($urandom_range(2 * span, 0)) - span;
  endfunction

  // Expected high time: copies the boundary pulse when the bit repeats, else HALF
  function automatic int exp_width(input int k);
    if (k + 1 < exp_n && exp_b[k] == exp_b[k+1]) return HALF - 1;
    return HALF;
  endfunction

  task automatic seg(input logic lv, input int n);
    repeat (n) begin
      @(negedge clk);
      line = lv;
    end
  endtask

  task automatic send_bit(input logic b, input int j1, input int j2);
    seg(!b, HALF + j1);
    seg(b, HALF + j2);
  endtask

  task automatic start_frame();
    exp_n = 0;
    rx_n  = 0;
    send_bit(1'b1, 0, 0);  // preamble: mid edge after idle is ignored
    send_bit(1'b0, 0, 0);  // full gap: lock, decoded
    exp_b[exp_n] = 1'b0;
    exp_n++;
  endtask

  task automatic payload(input logic b, input int span);
    send_bit(b, jit(span), jit(span));
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic end_frame(input logic last);
    seg(last, 6 * OSR);
    seg(1'b0, 6 * OSR);
  endtask

  task automatic compare(input string req);
    chk(rx_n == exp_n, {req, " bit count"}, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk(rx_d[i] == !exp_b[i], {req, " data_n at rise"}, int'(rx_d[i]), int'(!exp_b[i]));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(rc == 1'b0 && dn == 1'b1 && lk == 1'b0 && vf == 1'b0, "R1 reset outputs",
        {rc, dn, lk, vf}, 4'b0100);
    rst = 1'b0;
    @(negedge clk);
    chk(rc == 1'b0 && dn == 1'b1 && lk == 1'b0 && vf == 1'b0, "R1 after release",
        {rc, dn, lk, vf}, 4'b0100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic pat [0:9];
    void'($urandom(32'd2024));
    pat = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    do_reset();
    seg(1'b0, 50);

    // R4: all-ones stream has only half-bit gaps and must never lock
    rx_n = 0;
    for (int k = 0; k < 12; k++) send_bit(1'b1, 0, 0);
    chk(lk == 1'b0, "R4 no lock without full gap", lk, 0);
    end_frame(1'b1);
    chk(rx_n == 0, "R4 no rising edge while unlocked", rx_n, 0);

    // R2/R3/R5/R6: directed frame without jitter
    start_frame();
    chk(lk == 1'b1, "R4 locked after preamble", lk, 1);
    for (int k = 0; k < 10; k++) payload(pat[k], 0);
    end_frame(exp_b[exp_n-1]);
    compare("R2 R3");
    for (int k = 0; k + 1 < exp_n; k++)
      chk(rx_w[k] == exp_width(k), (exp_width(k) == HALF) ? "R6 high time" : "R5 high time",
          rx_w[k], exp_width(k));
    chk(rx_w[exp_n-1] == HALF, "R6 last bit high time", rx_w[exp_n-1], HALF);
    chk(lk == 1'b0, "R10 unlock on silence", lk, 0);
    chk(vf == 1'b0, "R10 no flag on silence", vf, 0);

    // R7: random frames with bounded jitter
    for (int f = 0; f < 4; f++) begin
      start_frame();
      for (int k = 0; k < 48; k++) payload(logic'($urandom_range(1, 0)), 2);
      end_frame(exp_b[exp_n-1]);
      compare("R7");
      chk(vf == 1'b0, "R7 no violation under jitter", vf, 0);
    end

    // R8: short glitch inside the second half of a 1
    start_frame();
    payload(1'b1, 0);
    payload(1'b0, 0);
    seg(1'b0, HALF);
    seg(1'b1, 3);
    seg(1'b0, 2);
    seg(1'b1, 3);
    exp_b[exp_n] = 1'b1;
    exp_n++;
    seg(1'b1, 6 * OSR);
    chk(vf == 1'b1, "R8 short pulse flags", vf, 1);
    chk(lk == 1'b0, "R8 short pulse unlocks", lk, 0);
    seg(1'b0, 6 * OSR);
    compare("R8");

    // R11: flag survives a clean frame and relock
    start_frame();
    payload(1'b0, 0);
    chk(lk == 1'b1 && vf == 1'b1, "R11 flag held while relocked", {lk, vf}, 2'b11);
    payload(1'b1, 0);
    end_frame(1'b1);
    compare("R11");
    chk(vf == 1'b1, "R11 flag still set", vf, 1);
    do_reset();
    chk(vf == 1'b0, "R11 cleared by reset", vf, 0);
    seg(1'b0, 50);

    // R9: pulse stretched past a full bit after a boundary
    start_frame();
    payload(1'b1, 0);
    seg(1'b0, HALF + 5);
    seg(1'b1, HALF);
    end_frame(1'b1);
    compare("R9");
    chk(vf == 1'b1, "R9 stretched pulse flags", vf, 1);
    chk(lk == 1'b0, "R9 stretched pulse unlocks", lk, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule